// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block turns the fill levels of a UART's receive and transmit FIFOs, together with single-cycle error and event pulses, into three words and one interrupt line. The live status word is recomputed every clock from the two fill counts and two programmable trigger levels. The sticky interrupt word latches every live condition and event until software clears it. The mask word decides which sticky bits can raise the level-sensitive interrupt output.

The surrounding register decoder sends write strobes and write data here. One strobe sets mask bits and another clears them, so there is no direct write path into the mask. A third strobe clears sticky bits, and two more load the trigger levels. The FIFO storage, the serial shifters and the bus decode are all outside this block.

Top module: `uart_irq_status_ctrl`

## Requirements
- R1: Live status bits are defined as follows, with full meaning a count equal to FIFO_DEPTH (64): bit 0 is set when the receive count is at or above its trigger level; bit 1 when the receive count is zero; bit 2 when the receive FIFO is full; bit 3 when the transmit count is zero; bit 4 when the transmit FIFO is full.
- R2: When the transmit count is at or above the transmit trigger level, the live status word shows this at bit 13, but the sticky word latches it at bit 10.
- R3: The live status output is registered. It reflects the counts and trigger levels that were present one clock earlier.
- R4: Every clock, live bits 4..0 are ORed into the same positions of the sticky word. A sticky bit falls only through a clear write.
- R5: The event pulses set these sticky bits: receive overrun at bit 5, framing error at bit 6, parity error at bit 7, receive timeout at bit 8, modem-status change at bit 9, and transmit overflow at bit 12. Bit 11 and bits above 12 always read zero.
- R6: A clear-strobe write clears every sticky bit whose write-data bit is 1 and leaves all other bits unchanged.
- R7: If a clear and a new set source hit the same sticky bit in the same cycle, the bit ends up set.
- R8: The mask changes only through two strobes. The enable strobe sets the mask bits written as 1, and the disable strobe clears them. If both strobes hit the same bit in one cycle, the bit is cleared. Only the implemented bit positions (0..10 and 12) are ever stored.
- R9: The interrupt output is registered and equals the OR of (mask AND sticky word). It changes on the same clock edge as the mask and sticky outputs it depends on.
- R10: While reset is asserted, the status, sticky and mask words and the interrupt output are all zero. Both trigger levels reset to 0x20.
- R11: The receive and transmit trigger levels can each be loaded through their own strobe. The new level takes effect in the compare on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| tx_cnt_i | input | CNT_W | Transmit FIFO fill count |
| rx_lvl_we_i | input | 1 | Load the receive trigger level |
| tx_lvl_we_i | input | 1 | Load the transmit trigger level |
| lvl_wdata_i | input | CNT_W | New trigger level value |
| ien_we_i | input | 1 | Mask set strobe (write 1 to enable) |
| idis_we_i | input | 1 | Mask clear strobe (write 1 to disable) |
| iclr_we_i | input | 1 | Sticky word clear strobe (write 1 to clear) |
| wdata_i | input | DATA_W | Write data for the mask and clear strobes |
| ev_rx_ovr_i | input | 1 | Receive overrun pulse |
| ev_frame_i | input | 1 | Framing error pulse |
| ev_parity_i | input | 1 | Parity error pulse |
| ev_rx_tmo_i | input | 1 | Receive timeout pulse |
| ev_modem_i | input | 1 | Modem-status change pulse |
| ev_tx_ovr_i | input | 1 | Transmit overflow pulse |
| stat_o | output | DATA_W | Registered live status word |
| isr_o | output | DATA_W | Sticky interrupt word |
| mask_o | output | DATA_W | Interrupt mask word |
| irq_o | output | 1 | Level interrupt output |

## Verification
Two pairs of functions can collide in one cycle. In the first, a clear write lands on a sticky bit that an event pulse or a live condition is setting at the same edge. In the second, an enable and a disable strobe name the same mask bit. The bench provokes the first by pulsing overrun while clearing bit 5, and by clearing all bits while the vector table applies fresh counts and events. It expects the newly set bits to survive and every other bit to drop. It provokes the second by raising both mask strobes with the same data and expects the bit to read cleared, with the interrupt output falling on the same edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // live status word bit positions
  localparam int ST_RX_TRIG  = 0;
  localparam int ST_RX_EMPTY = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_EMPTY = 3;
  localparam int ST_TX_FULL  = 4;
  localparam int ST_TX_TRIG  = 13;

  // sticky word bit positions (bits 4..0 mirror the live word)
  localparam int IS_RX_OVR  = 5;
  localparam int IS_FRAME   = 6;
  localparam int IS_PARITY  = 7;
  localparam int IS_RX_TMO  = 8;
  localparam int IS_MODEM   = 9;
  localparam int IS_TX_TRIG = 10;
  localparam int IS_TX_OVR  = 12;

  // implemented sticky / mask positions: 0..10 and 12
  localparam logic [15:0] IRQ_IMPL = 16'h17FF;

  typedef struct packed {
    logic tx_ovr;
    logic modem;
    logic rx_tmo;
    logic parity;
    logic frame;
    logic rx_ovr;
  } uart_evt_t;

endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level
  import uart_irq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int CNT_W    = 7,
  parameter int DATA_W   = 32,
  parameter int TRIG_RST = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic              rx_lvl_we_i,
  input  logic              tx_lvl_we_i,
  input  logic [CNT_W-1:0]  lvl_wdata_i,
  output logic [DATA_W-1:0] live_o,
  output logic [DATA_W-1:0] stat_o
);

  localparam int NDIR = 2;  // 0 = receive, 1 = transmit
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LVL_INIT = CNT_W'(TRIG_RST);

  logic [NDIR-1:0] at_trig;
  logic [NDIR-1:0] is_empty;
  logic [NDIR-1:0] is_full;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [CNT_W-1:0] lvl_q;
    logic [CNT_W-1:0] cnt;
    logic             we;

    assign cnt = (d == 0) ? rx_cnt_i : tx_cnt_i;
    assign we  = (d == 0) ? rx_lvl_we_i : tx_lvl_we_i;

    always_ff @(posedge clk) begin
      if (rst)     lvl_q <= LVL_INIT;
      else if (we) lvl_q <= lvl_wdata_i;
    end

    assign at_trig[d]  = (cnt >= lvl_q);
    assign is_empty[d] = (cnt == '0);
    assign is_full[d]  = (cnt == FULL_CNT);
  end

  always_comb begin
    live_o              = '0;
    live_o[ST_RX_TRIG]  = at_trig[0];
    live_o[ST_RX_EMPTY] = is_empty[0];
    live_o[ST_RX_FULL]  = is_full[0];
    live_o[ST_TX_EMPTY] = is_empty[1];
    live_o[ST_TX_FULL]  = is_full[1];
    live_o[ST_TX_TRIG]  = at_trig[1];
  end

  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= live_o;
  end

  // R1: a FIFO cannot read empty and full at once
  p_empty_full_r1: assert property (@(posedge clk) disable iff (rst)
    !(stat_o[ST_RX_EMPTY] && stat_o[ST_RX_FULL]) &&
    !(stat_o[ST_TX_EMPTY] && stat_o[ST_TX_FULL]));

endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] live_i,
  input  uart_evt_t         ev_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] clr_data_i,
  output logic [DATA_W-1:0] isr_d_o,
  output logic [DATA_W-1:0] isr_o
);

  localparam logic [DATA_W-1:0] IMPL = DATA_W'(IRQ_IMPL);

  logic [DATA_W-1:0] set_v;
  logic [DATA_W-1:0] clr_v;

  always_comb begin
    set_v = '0;
    for (int i = 0; i <= ST_TX_FULL; i++) set_v[i] = live_i[i];
    set_v[IS_TX_TRIG] = live_i[ST_TX_TRIG];
    set_v[IS_RX_OVR]  = ev_i.rx_ovr;
    set_v[IS_FRAME]   = ev_i.frame;
    set_v[IS_PARITY]  = ev_i.parity;
    set_v[IS_RX_TMO]  = ev_i.rx_tmo;
    set_v[IS_MODEM]   = ev_i.modem;
    set_v[IS_TX_OVR]  = ev_i.tx_ovr;
  end

  assign clr_v   = clr_we_i ? clr_data_i : '0;
  // set sources applied after the clear: a colliding new event survives
  assign isr_d_o = ((isr_o & ~clr_v) | set_v) & IMPL;

  always_ff @(posedge clk) begin
    if (rst) isr_o <= '0;
    else     isr_o <= isr_d_o;
  end

  // R4: without a clear write no sticky bit may fall
  p_no_drop_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_we_i |=> ((isr_o & $past(isr_o)) == $past(isr_o)));

  // R7: an overrun pulse leaves its bit set even under a clear
  p_ovr_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ev_i.rx_ovr |=> isr_o[IS_RX_OVR]);

  // R2: transmit trigger lands at the relocated sticky position
  p_tx_trig_map_r2: assert property (@(posedge clk) disable iff (rst)
    live_i[ST_TX_TRIG] |=> isr_o[IS_TX_TRIG]);

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] isr_d_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] IMPL = DATA_W'(IRQ_IMPL);

  logic [DATA_W-1:0] set_v;
  logic [DATA_W-1:0] clr_v;
  logic [DATA_W-1:0] mask_d;

  assign set_v  = set_we_i ? wdata_i : '0;
  assign clr_v  = clr_we_i ? wdata_i : '0;
  // disable applied last so it wins a same-cycle collision
  assign mask_d = ((mask_o | set_v) & ~clr_v) & IMPL;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      mask_o <= mask_d;
      irq_o  <= |(mask_d & isr_d_i);
    end
  end

  // R8: mask holds unless a mask strobe is raised
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!set_we_i && !clr_we_i) |=> $stable(mask_o));

  // R8: bits named by a disable write read cleared afterwards
  p_mask_disable_r8: assert property (@(posedge clk) disable iff (rst)
    clr_we_i |=> ((mask_o & $past(wdata_i)) == '0));

endmodule

// File: rtl/uart_irq_status_ctrl.sv
module uart_irq_status_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int CNT_W    = $clog2(DEPTH + 1),
  parameter int DATA_W   = 32,
  parameter int TRIG_RST = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic              rx_lvl_we_i,
  input  logic              tx_lvl_we_i,
  input  logic [CNT_W-1:0]  lvl_wdata_i,
  input  logic              ien_we_i,
  input  logic              idis_we_i,
  input  logic              iclr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ev_rx_ovr_i,
  input  logic              ev_frame_i,
  input  logic              ev_parity_i,
  input  logic              ev_rx_tmo_i,
  input  logic              ev_modem_i,
  input  logic              ev_tx_ovr_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] isr_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] live;
  logic [DATA_W-1:0] isr_d;
  uart_evt_t         ev;

  always_comb begin
    ev.rx_ovr = ev_rx_ovr_i;
    ev.frame  = ev_frame_i;
    ev.parity = ev_parity_i;
    ev.rx_tmo = ev_rx_tmo_i;
    ev.modem  = ev_modem_i;
    ev.tx_ovr = ev_tx_ovr_i;
  end

  uart_irq_level #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W), .TRIG_RST(TRIG_RST)
  ) u_level (
    .clk(clk), .rst(rst),
    .rx_cnt_i(rx_cnt_i), .tx_cnt_i(tx_cnt_i),
    .rx_lvl_we_i(rx_lvl_we_i), .tx_lvl_we_i(tx_lvl_we_i),
    .lvl_wdata_i(lvl_wdata_i),
    .live_o(live), .stat_o(stat_o)
  );

  uart_irq_sticky #(.DATA_W(DATA_W)) u_sticky (
    .clk(clk), .rst(rst),
    .live_i(live), .ev_i(ev),
    .clr_we_i(iclr_we_i), .clr_data_i(wdata_i),
    .isr_d_o(isr_d), .isr_o(isr_o)
  );

  uart_irq_mask #(.DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst(rst),
    .set_we_i(ien_we_i), .clr_we_i(idis_we_i),
    .wdata_i(wdata_i), .isr_d_i(isr_d),
    .mask_o(mask_o), .irq_o(irq_o)
  );

  // R9: interrupt line agrees with the mask and sticky outputs every cycle
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(mask_o & isr_o));

endmodule

// File: tb/uart_irq_status_ctrl_tb.sv
module uart_irq_status_ctrl_tb;

  localparam int DEPTH  = 64;
  localparam int CNT_W  = 7;
  localparam int DATA_W = 32;
  localparam int NVEC   = 9;

  // {rx_cnt, tx_cnt, events[5:0], expected status, expected sticky}
  // event bit order: 0 overrun, 1 framing, 2 parity, 3 timeout, 4 modem, 5 tx overflow
  localparam logic [51:0] VEC [NVEC] = '{
    {7'd0,  7'd0,  6'h00, 16'h000A, 16'h000A},
    {7'd32, 7'd0,  6'h00, 16'h0009, 16'h0009},
    {7'd64, 7'd64, 6'h00, 16'h2015, 16'h0415},
    {7'd31, 7'd31, 6'h00, 16'h0000, 16'h0000},
    {7'd5,  7'd40, 6'h00, 16'h2000, 16'h0400},
    {7'd10, 7'd10, 6'h3F, 16'h0000, 16'h13E0},
    {7'd0,  7'd33, 6'h01, 16'h2002, 16'h0422},
    {7'd63, 7'd1,  6'h20, 16'h0001, 16'h1001},
    {7'd64, 7'd0,  6'h08, 16'h000D, 16'h010D}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  rx_cnt = '0, tx_cnt = '0, lvl_wdata = '0;
  logic              rx_lvl_we = 0, tx_lvl_we = 0;
  logic              ien_we = 0, idis_we = 0, iclr_we = 0;
  logic [DATA_W-1:0] wdata = '0;
  logic [5:0]        ev = '0;
  logic [DATA_W-1:0] stat, isr, mask;
  logic              irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  uart_irq_status_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst),
    .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
    .rx_lvl_we_i(rx_lvl_we), .tx_lvl_we_i(tx_lvl_we), .lvl_wdata_i(lvl_wdata),
    .ien_we_i(ien_we), .idis_we_i(idis_we), .iclr_we_i(iclr_we), .wdata_i(wdata),
    .ev_rx_ovr_i(ev[0]), .ev_frame_i(ev[1]), .ev_parity_i(ev[2]),
    .ev_rx_tmo_i(ev[3]), .ev_modem_i(ev[4]), .ev_tx_ovr_i(ev[5]),
    .stat_o(stat), .isr_o(isr), .mask_o(mask), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    rx_lvl_we = 0; tx_lvl_we = 0; ien_we = 0; idis_we = 0; iclr_we = 0;
    ev = '0; wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 status in reset", stat, 32'h0);
    chk("R10 sticky in reset", isr, 32'h0);
    chk("R10 mask in reset", mask, 32'h0);
    chk("R10 irq in reset", {31'd0, irq}, 32'h0);
    rst = 0;

    // R8: enable all, only implemented bits kept
    ien_we = 1; wdata = '1;
    @(negedge clk);
    chk("R8 mask implemented bits", mask, 32'h17FF);
    idle_strobes();

    // table: clear everything while applying counts and events (R1 R2 R5 R7 R9 R10 trigger 0x20)
    for (int i = 0; i < NVEC; i++) begin
      rx_cnt = VEC[i][51:45]; tx_cnt = VEC[i][44:38]; ev = VEC[i][37:32];
      iclr_we = 1; wdata = '1;
      @(negedge clk);
      chk("R1/R2 status vector", stat, {16'h0, VEC[i][31:16]});
      chk("R5/R7 sticky vector", isr, {16'h0, VEC[i][15:0]});
      chk("R9 irq vector", {31'd0, irq}, {31'd0, VEC[i][15:0] != 16'h0});
      idle_strobes();
    end

    // R4 / R3: sticky hold after condition drops, status lags one cycle
    rx_cnt = 7'd64; tx_cnt = 7'd10; iclr_we = 1; wdata = '1;
    @(negedge clk);
    chk("R4 sticky after full", isr, 32'h0005);
    idle_strobes(); rx_cnt = 7'd10;
    @(negedge clk);
    chk("R3 status one cycle later", stat, 32'h0000);
    chk("R4 sticky held", isr, 32'h0005);

    // R6: partial write-one-to-clear
    iclr_we = 1; wdata = 32'h4;
    @(negedge clk);
    chk("R6 partial clear", isr, 32'h0001);
    idle_strobes();

    // R7: clear and overrun collide on bit 5
    iclr_we = 1; wdata = 32'h21; ev = 6'h01;
    @(negedge clk);
    chk("R7 event beats clear", isr, 32'h0020);
    chk("R9 irq with overrun", {31'd0, irq}, 32'h1);
    idle_strobes();

    // R8 / R9: mask manipulation
    idis_we = 1; wdata = '1;
    @(negedge clk);
    chk("R8 disable all", mask, 32'h0);
    chk("R9 irq masked", {31'd0, irq}, 32'h0);
    idle_strobes(); ien_we = 1; wdata = 32'h40;
    @(negedge clk);
    chk("R8 enable framing", mask, 32'h0040);
    chk("R9 irq unmatched", {31'd0, irq}, 32'h0);
    idle_strobes(); ien_we = 1; wdata = 32'h20;
    @(negedge clk);
    chk("R8 enable overrun", mask, 32'h0060);
    chk("R9 irq raised", {31'd0, irq}, 32'h1);
    idle_strobes(); ien_we = 1; idis_we = 1; wdata = 32'h20;
    @(negedge clk);
    chk("R8 disable wins", mask, 32'h0040);
    chk("R9 irq dropped", {31'd0, irq}, 32'h0);
    idle_strobes();

    // R11: trigger level writes take effect one cycle later
    rx_lvl_we = 1; lvl_wdata = 7'd5;
    @(negedge clk);
    chk("R11 old level still used", stat, 32'h0000);
    idle_strobes();
    @(negedge clk);
    chk("R11 new receive level", stat, 32'h0001);
    tx_lvl_we = 1; lvl_wdata = 7'd0;
    @(negedge clk);
    idle_strobes();
    @(negedge clk);
    chk("R11 transmit level zero", stat, 32'h2001);
    chk("R2 sticky tx trigger", isr, 32'h0421);
    rx_cnt = 7'd4;
    @(negedge clk);
    chk("R11 below receive level", stat, 32'h2000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule